// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host write port of a NOR-style flash and turns sequences of bus write cycles into internal commands. It watches each write's address and data and follows the unlock-and-command sequences for word program, chip erase, sector erase, autoselect entry and exit, and unlock-bypass entry and exit. Each accepted command comes out as a single-cycle pulse. The pulse carries its address and data, or the set of sectors to erase. The embedded algorithms that carry out the command are outside this block.

Two side inputs change how sequences are handled. A read-mode flag says whether the device is in synchronous read mode, and autoselect can only be entered when it is not. A two-bit accelerate level has three effects. At the lock level, every program or erase is refused. At the boost level, the decoder is forced into the short two-write program mode. At any other level, the decoder behaves normally. Sector erase keeps a window open after each sector write so that further sectors can join the same erase. The width of that window comes from a host-supplied cycle count.

Top module: `flcmd_decoder`

## Requirements
- R1: After reset, with the accelerate level normal, no pulse is active, autoselect mode is off and bypass mode is off.
- R2: Writing 0xAA to address 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555, and then any data D to any address A (D not 0xF0) makes prog_pulse high for exactly the cycle after the fourth write, with prog_addr = A and prog_data = D. Unlock addresses are compared on the low 11 address bits.
- R3: The unlock pair followed by 0x20 at 0x555 turns bypass mode on. While bypass mode is on, 0xA0 to any address followed by one data write programs that word. A write of 0x90 followed by a write of 0x00 turns bypass mode off.
- R4: The accelerate encoding is 2'b00 lock, 2'b01 normal, 2'b10 boost and 2'b11 normal. At boost, bypass_mode reads 1 and two-write programs are accepted. Returning to normal ends bypass mode unless bypass was entered by command.
- R5: While the accelerate level is lock when a program or erase would be issued, refuse_pulse is raised for one cycle in place of prog_pulse or erase_pulse.
- R6: The unlock pair followed by 0x90 at 0x555 sets autoselect mode only when sync_mode is 0. With sync_mode at 1, the attempt is ignored. In autoselect mode, command sequences are ignored, and 0xF0 clears the mode.
- R7: The unlock pair, 0x80 at 0x555, the unlock pair again, and 0x10 at 0x555 issue an erase pulse with erase_all = 1 and every sector bit set.
- R8: The unlock pair, 0x80, the unlock pair, and then 0x30 to an address open sector collection. The sector index is the top 3 address bits, and each one sets bit index in erase_sectors. Every further 0x30 write adds its sector and restarts the window. The erase pulse appears max(tmo_limit,1) cycles after the last 0x30 write, with erase_all = 0.
- R9: A write that does not match the next expected step of a sequence returns the decoder to idle. A following fresh sequence is then accepted.
- R10: Data 0xF0 at any step returns the decoder to idle and discards an open sector collection, but does not end bypass mode.
- R11: Program sequences are accepted identically whatever the value of sync_mode.
- R12: Any write other than 0x30 during sector collection abandons the erase, so no erase pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One write cycle this clock |
| wr_addr | input | 12 | Write address |
| wr_data | input | 8 | Write data |
| sync_mode | input | 1 | 1 when the device is in synchronous read mode |
| acc_lvl | input | 2 | Accelerate level: 00 lock, 01 normal, 10 boost, 11 normal |
| tmo_limit | input | 8 | Sector collection window in cycles (0 treated as 1) |
| prog_pulse | output | 1 | Word program issued |
| prog_addr | output | 12 | Program address |
| prog_data | output | 8 | Program data |
| erase_pulse | output | 1 | Erase issued |
| erase_all | output | 1 | Erase is a chip erase |
| erase_sectors | output | 8 | Sectors to erase, one bit per sector |
| refuse_pulse | output | 1 | Program or erase refused by lock level |
| autosel_mode | output | 1 | Autoselect mode active |
| bypass_mode | output | 1 | Two-write program mode active |

## Verification
The window checks assume that tmo_limit does not change while a sector collection is open. The refusal checks assume that acc_lvl, as sampled on the clock before a pulse, is the level that decided it. The stimulus sets tmo_limit and acc_lvl only between commands and never inside a collection window. It drives every write as a one-cycle strobe that changes only on the falling clock edge. The erase sweeps space follow-up sector writes one cycle inside the window, so the restart rule is exercised at its edge without the window being allowed to lapse.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
    parameter int ADDR_W = 12;
    parameter int DATA_W = 8;
    parameter int SECT_W = 3;
    parameter int NSECT  = 1 << SECT_W;
    parameter int UNLK_W = 11;
    parameter int TMO_W  = 8;

    localparam logic [UNLK_W-1:0] UNLK_ADDR_A = UNLK_W'(12'h555);
    localparam logic [UNLK_W-1:0] UNLK_ADDR_B = UNLK_W'(12'h2AA);

    localparam logic [DATA_W-1:0] CMD_UNLK_A = DATA_W'(8'hAA);
    localparam logic [DATA_W-1:0] CMD_UNLK_B = DATA_W'(8'h55);
    localparam logic [DATA_W-1:0] CMD_PROG   = DATA_W'(8'hA0);
    localparam logic [DATA_W-1:0] CMD_ESETUP = DATA_W'(8'h80);
    localparam logic [DATA_W-1:0] CMD_SECTOR = DATA_W'(8'h30);
    localparam logic [DATA_W-1:0] CMD_CHIP   = DATA_W'(8'h10);
    localparam logic [DATA_W-1:0] CMD_ASEL   = DATA_W'(8'h90);
    localparam logic [DATA_W-1:0] CMD_BYPASS = DATA_W'(8'h20);
    localparam logic [DATA_W-1:0] CMD_BXIT   = DATA_W'(8'h00);
    localparam logic [DATA_W-1:0] CMD_RESET  = DATA_W'(8'hF0);

    typedef enum logic [1:0] {
        ACC_LOCK  = 2'b00,
        ACC_NORM  = 2'b01,
        ACC_BOOST = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_lvl_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PDATA,
        SQ_ES, SQ_EU1, SQ_EU2, SQ_COLLECT, SQ_BXIT
    } seq_st_e;

    typedef struct packed {
        logic              valid;
        logic              is_reset;
        logic              unlk_a;
        logic              unlk_b;
        logic              cmd_addr;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } wr_tok_t;

    function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SECT_W];
    endfunction
endpackage

// File: rtl/flcmd_match.sv
module flcmd_match
    import flcmd_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_tok_t           tok
);
    logic [UNLK_W-1:0] low_addr;
    logic              at_a;
    logic              at_b;

    assign low_addr = wr_addr[UNLK_W-1:0];
    assign at_a     = (low_addr == UNLK_ADDR_A);
    assign at_b     = (low_addr == UNLK_ADDR_B);

    always_comb begin
        tok.valid    = wr_en;
        tok.is_reset = (wr_data == CMD_RESET);
        tok.cmd_addr = at_a;
        tok.unlk_a   = at_a && (wr_data == CMD_UNLK_A);
        tok.unlk_b   = at_b && (wr_data == CMD_UNLK_B);
        tok.data     = wr_data;
        tok.addr     = wr_addr;
    end
endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_tok_t tok,
    input  logic    sync_mode,
    input  logic    acc_boost,
    input  logic    col_done,
    output logic    prog_req,
    output logic    chip_req,
    output logic    sect_start,
    output logic    sect_add,
    output logic    col_abort,
    output logic    autosel,
    output logic    bypass_cmd
);
    seq_st_e state_q, state_d;
    logic    asel_set, asel_clr, byp_set, byp_clr;
    logic    byp_eff;

    assign byp_eff = bypass_cmd | acc_boost;

    always_comb begin
        state_d    = state_q;
        prog_req   = 1'b0;
        chip_req   = 1'b0;
        sect_start = 1'b0;
        sect_add   = 1'b0;
        col_abort  = 1'b0;
        asel_set   = 1'b0;
        asel_clr   = 1'b0;
        byp_set    = 1'b0;
        byp_clr    = 1'b0;
        if (tok.valid) begin
            if (tok.is_reset) begin
                state_d   = SQ_IDLE;
                asel_clr  = 1'b1;
                col_abort = (state_q == SQ_COLLECT);
            end else begin
                state_d = SQ_IDLE;
                case (state_q)
                    SQ_IDLE: begin
                        if (autosel)                        state_d = SQ_IDLE;
                        else if (byp_eff && tok.data == CMD_PROG) state_d = SQ_PDATA;
                        else if (byp_eff && tok.data == CMD_ASEL) state_d = SQ_BXIT;
                        else if (!byp_eff && tok.unlk_a)    state_d = SQ_U1;
                    end
                    SQ_U1:  if (tok.unlk_b) state_d = SQ_U2;
                    SQ_U2: begin
                        if (tok.cmd_addr) begin
                            case (tok.data)
                                CMD_PROG:   state_d = SQ_PDATA;
                                CMD_ESETUP: state_d = SQ_ES;
                                CMD_BYPASS: byp_set = 1'b1;
                                CMD_ASEL:   asel_set = !sync_mode;
                                default:    state_d = SQ_IDLE;
                            endcase
                        end
                    end
                    SQ_PDATA: prog_req = 1'b1;
                    SQ_ES:  if (tok.unlk_a) state_d = SQ_EU1;
                    SQ_EU1: if (tok.unlk_b) state_d = SQ_EU2;
                    SQ_EU2: begin
                        if (tok.cmd_addr && tok.data == CMD_CHIP) begin
                            chip_req = 1'b1;
                        end else if (tok.data == CMD_SECTOR) begin
                            sect_start = 1'b1;
                            state_d    = SQ_COLLECT;
                        end
                    end
                    SQ_COLLECT: begin
                        if (tok.data == CMD_SECTOR) begin
                            sect_add = 1'b1;
                            state_d  = SQ_COLLECT;
                        end else begin
                            col_abort = 1'b1;
                        end
                    end
                    SQ_BXIT: byp_clr = (tok.data == CMD_BXIT);
                    default: state_d = SQ_IDLE;
                endcase
            end
        end else if (state_q == SQ_COLLECT && col_done) begin
            state_d = SQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            autosel    <= 1'b0;
            bypass_cmd <= 1'b0;
        end else begin
            state_q <= state_d;
            if (asel_set)      autosel <= 1'b1;
            else if (asel_clr) autosel <= 1'b0;
            if (byp_set)       bypass_cmd <= 1'b1;
            else if (byp_clr)  bypass_cmd <= 1'b0;
        end
    end

    // R6
    autosel_async_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(autosel) |-> !$past(sync_mode));

    // R3
    bypass_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_cmd) |-> ($past(state_q) == SQ_U2 && $past(tok.data) == CMD_BYPASS));

    // R4
    boost_short_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_boost && !autosel && state_q == SQ_IDLE && tok.valid && tok.data == CMD_PROG)
        |=> state_q == SQ_PDATA);
endmodule

// File: rtl/flcmd_erase_acc.sv
module flcmd_erase_acc
    import flcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              add,
    input  logic              abort,
    input  logic              hold,
    input  logic [SECT_W-1:0] sect,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              done,
    output logic [NSECT-1:0]  mask
);
    logic             active_q;
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] last_cnt;
    logic [NSECT-1:0] mask_d;

    assign last_cnt = (tmo_limit == '0) ? '0 : tmo_limit - TMO_W'(1);
    assign done     = active_q && !hold && (cnt_q >= last_cnt);

    for (genvar g = 0; g < NSECT; g++) begin : g_bit
        logic hit;
        assign hit       = (sect == SECT_W'(g));
        assign mask_d[g] = start ? hit : (mask[g] | (add & hit));
    end

    always_ff @(posedge clk) begin
        if (rst || abort || done) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            mask     <= '0;
        end else if (start || add) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            mask     <= mask_d;
        end else if (active_q) begin
            cnt_q <= cnt_q + TMO_W'(1);
        end
    end

    // R8
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active_q |-> cnt_q <= last_cnt);

    // R8
    flush_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> mask != '0);
endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
    import flcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sync_mode,
    input  logic [1:0]        acc_lvl,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              prog_pulse,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_pulse,
    output logic              erase_all,
    output logic [NSECT-1:0]  erase_sectors,
    output logic              refuse_pulse,
    output logic              autosel_mode,
    output logic              bypass_mode
);
    wr_tok_t          tok;
    acc_lvl_e         acc;
    logic             locked, boost;
    logic             prog_req, chip_req, sect_start, sect_add, col_abort;
    logic             col_done, byp_cmd, issue_erase;
    logic [NSECT-1:0] col_mask;

    assign acc    = acc_lvl_e'(acc_lvl);
    assign locked = (acc == ACC_LOCK);
    assign boost  = (acc == ACC_BOOST);

    flcmd_match u_match (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tok     (tok)
    );

    flcmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .tok        (tok),
        .sync_mode  (sync_mode),
        .acc_boost  (boost),
        .col_done   (col_done),
        .prog_req   (prog_req),
        .chip_req   (chip_req),
        .sect_start (sect_start),
        .sect_add   (sect_add),
        .col_abort  (col_abort),
        .autosel    (autosel_mode),
        .bypass_cmd (byp_cmd)
    );

    flcmd_erase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .start     (sect_start),
        .add       (sect_add),
        .abort     (col_abort),
        .hold      (tok.valid),
        .sect      (sect_of(tok.addr)),
        .tmo_limit (tmo_limit),
        .done      (col_done),
        .mask      (col_mask)
    );

    assign bypass_mode = byp_cmd | boost;
    assign issue_erase = chip_req | col_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_pulse    <= 1'b0;
            prog_addr     <= '0;
            prog_data     <= '0;
            erase_pulse   <= 1'b0;
            erase_all     <= 1'b0;
            erase_sectors <= '0;
            refuse_pulse  <= 1'b0;
        end else begin
            prog_pulse   <= prog_req & !locked;
            erase_pulse  <= issue_erase & !locked;
            refuse_pulse <= (prog_req | issue_erase) & locked;
            if (prog_req) begin
                prog_addr <= tok.addr;
                prog_data <= tok.data;
            end
            if (issue_erase) begin
                erase_all     <= chip_req;
                erase_sectors <= chip_req ? '1 : col_mask;
            end
        end
    end

    // R5
    refuse_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        refuse_pulse |-> $past(acc_lvl) == ACC_LOCK);

    // R5
    one_issue_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_pulse, erase_pulse, refuse_pulse}));

    // R2
    prog_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        prog_pulse |-> $past(wr_en) && prog_addr == $past(wr_addr) && prog_data == $past(wr_data));
endmodule

// File: tb/sim_flcmd_decoder.sv
module sim_flcmd_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        sync_mode;
    logic [1:0]  acc_lvl;
    logic [7:0]  tmo_limit;
    logic        prog_pulse, erase_pulse, erase_all, refuse_pulse, autosel_mode, bypass_mode;
    logic [11:0] prog_addr;
    logic [7:0]  prog_data;
    logic [7:0]  erase_sectors;

    int checks = 0;
    int fails  = 0;

    logic        s_prog, s_er, s_all, s_ref;
    logic [11:0] s_paddr;
    logic [7:0]  s_pdata, s_sect;

    always #5 clk = ~clk;

    flcmd_decoder u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sync_mode(sync_mode), .acc_lvl(acc_lvl), .tmo_limit(tmo_limit),
        .prog_pulse(prog_pulse), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_pulse(erase_pulse), .erase_all(erase_all), .erase_sectors(erase_sectors),
        .refuse_pulse(refuse_pulse), .autosel_mode(autosel_mode), .bypass_mode(bypass_mode)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic grab();
        s_prog = prog_pulse; s_paddr = prog_addr; s_pdata = prog_data;
        s_er = erase_pulse; s_all = erase_all; s_sect = erase_sectors; s_ref = refuse_pulse;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        grab();
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock(); wr(12'h555, 8'h80); unlock();
    endtask

    // idle n cycles; returns 1 if any pulse seen
    task automatic idle(input int n, output logic any);
        any = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (prog_pulse || erase_pulse || refuse_pulse) any = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic any;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        sync_mode = 1'b0; acc_lvl = 2'b01; tmo_limit = 8'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!prog_pulse && !erase_pulse && !refuse_pulse, "R1 pulses", {prog_pulse, erase_pulse, refuse_pulse}, 0);
        chk(!autosel_mode && !bypass_mode, "R1 modes", {autosel_mode, bypass_mode}, 0);

        // R2 R5 R11 program sweep over accelerate levels and read mode
        for (int acc = 0; acc < 4; acc++) begin
            for (int sm = 0; sm < 2; sm++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [11:0] a;
                    logic [7:0]  d;
                    a = 12'((k * 'h3A1 + acc * 'h111 + sm) & 'hFFF);
                    d = 8'((k * 37 + acc * 11 + sm * 5 + 1) & 'hFF);
                    if (d == 8'hF0) d = 8'h0F;
                    acc_lvl = 2'(acc); sync_mode = sm[0];
                    unlock(); wr(12'h555, 8'hA0); wr(a, d);
                    if (acc == 0) begin
                        chk(s_ref && !s_prog, "R5 program refused", {s_prog, s_ref}, 1);
                    end else begin
                        chk(s_prog && !s_ref, "R2 R11 program issued", {s_prog, s_ref}, 2);
                        chk(s_paddr == a && s_pdata == d, "R2 program addr/data", {s_paddr, s_pdata}, {a, d});
                    end
                    idle(1, any);
                    chk(!any, "R2 single pulse", 32'(any), 0);
                end
            end
        end
        sync_mode = 1'b0;

        // R4 boost forces two-write programming
        acc_lvl = 2'b10;
        @(negedge clk);
        chk(bypass_mode, "R4 boost bypass", 32'(bypass_mode), 1);
        for (int k = 0; k < 4; k++) begin
            logic [11:0] a;
            a = 12'(k * 'h401 + 7);
            wr(12'(k * 'h123), 8'hA0); wr(a, 8'(k + 'h40));
            chk(s_prog && s_paddr == a && s_pdata == 8'(k + 'h40), "R4 short program", {s_prog, s_pdata}, {1'b1, 8'(k + 'h40)});
        end
        acc_lvl = 2'b01;
        @(negedge clk);
        chk(!bypass_mode, "R4 boost removed", 32'(bypass_mode), 0);
        wr(12'h010, 8'hA0); wr(12'h020, 8'h33);
        chk(!s_prog, "R4 short program after boost removed", 32'(s_prog), 0);

        // R3 bypass by command
        unlock(); wr(12'h555, 8'h20);
        chk(bypass_mode, "R3 bypass entered", 32'(bypass_mode), 1);
        for (int k = 0; k < 3; k++) begin
            wr(12'h000, 8'hA0); wr(12'(k * 'h555), 8'(k * 3 + 1));
            chk(s_prog && s_paddr == 12'(k * 'h555) && s_pdata == 8'(k * 3 + 1), "R3 two-write program", {s_prog, s_pdata}, {1'b1, 8'(k * 3 + 1)});
        end
        // R10 reset data keeps bypass
        wr(12'h000, 8'hF0);
        chk(bypass_mode, "R10 bypass kept after F0", 32'(bypass_mode), 1);
        wr(12'h000, 8'h90); wr(12'h000, 8'h00);
        chk(!bypass_mode, "R3 bypass exit", 32'(bypass_mode), 0);

        // R6 autoselect
        sync_mode = 1'b1;
        unlock(); wr(12'h555, 8'h90);
        @(negedge clk);
        chk(!autosel_mode, "R6 autoselect ignored in sync mode", 32'(autosel_mode), 0);
        sync_mode = 1'b0;
        unlock(); wr(12'h555, 8'h90);
        @(negedge clk);
        chk(autosel_mode, "R6 autoselect entered", 32'(autosel_mode), 1);
        unlock(); wr(12'h555, 8'hA0); wr(12'h100, 8'h12);
        chk(!s_prog, "R6 command ignored in autoselect", 32'(s_prog), 0);
        wr(12'h000, 8'hF0);
        @(negedge clk);
        chk(!autosel_mode, "R6 autoselect cleared", 32'(autosel_mode), 0);

        // R9 broken sequences
        unlock(); wr(12'h555, 8'h77); wr(12'h123, 8'h45);
        chk(!s_prog, "R9 wrong command", 32'(s_prog), 0);
        wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'hA0); wr(12'h321, 8'h46);
        chk(!s_prog, "R9 wrong unlock address", 32'(s_prog), 0);
        unlock(); wr(12'h555, 8'hA0); wr(12'h321, 8'h46);
        chk(s_prog && s_pdata == 8'h46, "R9 fresh sequence accepted", 32'(s_pdata), 'h46);

        // R10 F0 mid-program
        unlock(); wr(12'h555, 8'hA0); wr(12'h200, 8'hF0);
        idle(2, any);
        chk(!s_prog && !any, "R10 F0 aborts program", 32'(s_prog), 0);

        // R7 chip erase, normal and locked
        erase_prefix(); wr(12'h555, 8'h10);
        chk(s_er && s_all && s_sect == 8'hFF, "R7 chip erase", {s_er, s_all, s_sect}, {2'b11, 8'hFF});
        acc_lvl = 2'b00;
        erase_prefix(); wr(12'h555, 8'h10);
        chk(s_ref && !s_er, "R5 chip erase refused", {s_er, s_ref}, 1);
        acc_lvl = 2'b01;

        // R8 sector collection sweep
        for (int lim = 1; lim <= 5; lim++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] m;
                logic       first;
                int         n;
                m = (p == 0) ? 8'h01 : (p == 1) ? 8'h81 : (p == 2) ? 8'h5A : 8'(lim * 37 + 1);
                tmo_limit = 8'(lim);
                first = 1'b1;
                any = 1'b0;
                for (int s = 0; s < 8; s++) begin
                    if (m[s]) begin
                        if (first) begin
                            erase_prefix();
                            first = 1'b0;
                        end else if (lim >= 2) begin
                            logic g;
                            idle(lim - 2, g);
                            any = any | g;
                        end
                        wr(12'((s << 9) | 'h1F), 8'h30);
                    end
                end
                n = 0;
                for (int i = 1; i <= lim + 5; i++) begin
                    @(negedge clk);
                    if (erase_pulse || refuse_pulse) begin n = i; break; end
                end
                chk(!any, "R8 no early erase", 32'(any), 0);
                chk(n == lim, "R8 window length", n, lim);
                chk(erase_pulse && !erase_all && erase_sectors == m, "R8 sector set", erase_sectors, m);
            end
        end

        // R0 zero limit behaves as one
        tmo_limit = 8'd0;
        erase_prefix(); wr(12'hE00, 8'h30);
        @(negedge clk);
        chk(erase_pulse && erase_sectors == 8'h80, "R8 zero limit", erase_sectors, 'h80);

        // R5 locked sector erase
        tmo_limit = 8'd2;
        acc_lvl = 2'b00;
        erase_prefix(); wr(12'h200, 8'h30);
        idle(2, any);
        chk(refuse_pulse && !erase_pulse, "R5 sector erase refused", {erase_pulse, refuse_pulse}, 1);
        acc_lvl = 2'b01;

        // R12 foreign write during collection
        tmo_limit = 8'd4;
        erase_prefix(); wr(12'h400, 8'h30); wr(12'h400, 8'h77);
        idle(8, any);
        chk(!any, "R12 collection abandoned", 32'(any), 0);

        // R10 F0 during collection
        erase_prefix(); wr(12'h600, 8'h30); wr(12'h600, 8'hF0);
        idle(8, any);
        chk(!any, "R10 F0 discards collection", 32'(any), 0);

        // R9 decoder usable after aborts
        unlock(); wr(12'h555, 8'hA0); wr(12'h0AB, 8'hCD);
        chk(s_prog && s_paddr == 12'h0AB, "R9 program after abort", 32'(s_paddr), 'h0AB);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule